// File: doc/BRIEF.md
# Trace Frame Word Unpacker

This block turns 32-bit words read back from a trace capture memory into a stream of per-cycle trace records. Each record carries a 3-bit pipeline status, a packet field of up to 16 bits, a sync flag and a trigger flag. A 2-bit port-width mode, sampled together with each word, decides how many records the word contains. A 4-bit port packs three records into a word, an 8-bit port packs two, and a 16-bit port packs one.

Both the word input and the record output are valid/ready streams. A word is taken only once every record of the word already held has been handed on. The last record and the next word may change hands in the same cycle, so a stream with no back-pressure loses no cycles. While the consumer holds ready low, the record on offer stays fixed and no new word is taken. A record whose status carries the trigger code leaves with its status replaced by the low packet bits and with the trigger flag set.

Top module: `trace_unpk`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Mode 2'b00 (4-bit port) gives three records per word. Record k (k = 0, 1, 2) has status at word bits [8k+2:8k], packet at [8k+6:8k+3] and sync at bit 8k+7.
- R3: Mode 2'b01 (8-bit port) gives two records per word. Record k (k = 0, 1) has status at [12k+2:12k], packet at [12k+10:12k+3] and sync at bit 12k+11.
- R4: Modes 2'b10 and 2'b11 (16-bit port) give one record per word, with status at [2:0], packet at [18:3] and sync at bit 19.
- R5: The records of a word leave in order from the lowest bit group to the highest, and the first record is offered in the cycle after the word is taken.
- R6: A record whose raw status is 3'b110 leaves with its status equal to packet bits [2:0] and out_trig set to 1. For any other raw status, out_trig is 0 and the status is passed through unchanged.
- R7: out_packet is zero-extended to 16 bits in the 4-bit and 8-bit modes.
- R8: While out_valid is 1 and out_ready is 0, every output field holds its value in the next cycle.
- R9: in_ready is 0 while a record that is not the last of its word is on offer. A new word can be taken in the same cycle that the last record is taken.
- R10: The mode is captured with the word. A change of in_mode while a word is held has no effect on that word's records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_mode | input | 2 | Port-width mode, captured with each word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed trace word |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_status | output | 3 | Pipeline status (trigger code rewritten) |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag |
| out_trig | output | 1 | Trigger cycle flag |

## Verification
On every cycle, the assertions check several properties. The output must stay stable under back-pressure, and the input must stay blocked while a non-final record waits. Each word must start at its lowest record. No trigger code may leave unflagged, and the 4-bit mode must keep the upper packet bits zero. Only the scenarios can show the field positions and record counts in each mode, the trigger rewrite at every record slot, the 16-bit behaviour of the spare mode code, and the fact that a later change of in_mode leaves a held word alone. The bench compares each record, in order, against values it builds from the bit layouts, with the consumer always ready, randomly ready and stalled.

// File: rtl/trace_unpk_pkg.sv
package trace_unpk_pkg;
  typedef enum logic [1:0] {
    PW_4   = 2'b00,
    PW_8   = 2'b01,
    PW_16  = 2'b10,
    PW_16B = 2'b11
  } port_w_e;

  // per-mode geometry: bit stride between records and packet width
  localparam int unsigned NARROW_STRIDE = 8;
  localparam int unsigned NARROW_PKT    = 4;
  localparam int unsigned NARROW_RECS   = 3;
  localparam int unsigned MID_STRIDE    = 12;
  localparam int unsigned MID_PKT       = 8;
  localparam int unsigned MID_RECS      = 2;
  localparam int unsigned WIDE_PKT      = 16;
endpackage

// File: rtl/trace_unpk_extract.sv
module trace_unpk_extract
  import trace_unpk_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned STAT_W = 3,
  parameter int unsigned PKT_W  = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  port_w_e           mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [STAT_W-1:0] stat,
  output logic [PKT_W-1:0]  pkt,
  output logic              sync,
  output logic              last
);
  logic [STAT_W-1:0]     st_n [NARROW_RECS];
  logic [NARROW_PKT-1:0] pk_n [NARROW_RECS];
  logic                  sy_n [NARROW_RECS];
  logic [STAT_W-1:0]     st_m [MID_RECS];
  logic [MID_PKT-1:0]    pk_m [MID_RECS];
  logic                  sy_m [MID_RECS];

  for (genvar g = 0; g < NARROW_RECS; g++) begin : g_narrow
    localparam int unsigned B = g * NARROW_STRIDE;
    assign st_n[g] = word[B +: STAT_W];
    assign pk_n[g] = word[B + STAT_W +: NARROW_PKT];
    assign sy_n[g] = word[B + STAT_W + NARROW_PKT];
  end

  for (genvar g = 0; g < MID_RECS; g++) begin : g_mid
    localparam int unsigned B = g * MID_STRIDE;
    assign st_m[g] = word[B +: STAT_W];
    assign pk_m[g] = word[B + STAT_W +: MID_PKT];
    assign sy_m[g] = word[B + STAT_W + MID_PKT];
  end

  always_comb begin
    stat = word[STAT_W-1:0];
    pkt  = word[STAT_W +: WIDE_PKT];
    sync = word[STAT_W + WIDE_PKT];
    last = 1'b1;
    case (mode)
      PW_4: begin
        last = (idx == IDX_W'(NARROW_RECS - 1));
        case (idx)
          IDX_W'(1): begin stat = st_n[1]; pkt = PKT_W'(pk_n[1]); sync = sy_n[1]; end
          IDX_W'(2): begin stat = st_n[2]; pkt = PKT_W'(pk_n[2]); sync = sy_n[2]; end
          default:   begin stat = st_n[0]; pkt = PKT_W'(pk_n[0]); sync = sy_n[0]; end
        endcase
      end
      PW_8: begin
        last = (idx == IDX_W'(MID_RECS - 1));
        if (idx == IDX_W'(1)) begin
          stat = st_m[1]; pkt = PKT_W'(pk_m[1]); sync = sy_m[1];
        end else begin
          stat = st_m[0]; pkt = PKT_W'(pk_m[0]); sync = sy_m[0];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trace_unpk_trigfix.sv
module trace_unpk_trigfix #(
  parameter int unsigned        STAT_W    = 3,
  parameter int unsigned        PKT_W     = 16,
  parameter logic [STAT_W-1:0]  TRIG_CODE = 3'b110
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [PKT_W-1:0]  pkt_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              trig_o
);
  always_comb begin
    trig_o = (stat_i == TRIG_CODE);
    stat_o = trig_o ? pkt_i[STAT_W-1:0] : stat_i;
  end
endmodule

// File: rtl/trace_unpk_seq.sv
module trace_unpk_seq
  import trace_unpk_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  port_w_e           in_mode,
  output logic              in_ready,
  input  logic              out_ready,
  input  logic              last,
  output logic              out_valid,
  output logic [WORD_W-1:0] word_q,
  output port_w_e           mode_q,
  output logic [IDX_W-1:0]  idx_q
);
  logic out_fire, word_done, accept;

  assign out_fire  = out_valid & out_ready;
  assign word_done = out_fire & last;
  assign in_ready  = ~out_valid | word_done;
  assign accept    = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      word_q    <= '0;
      mode_q    <= PW_4;
      idx_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      word_q    <= in_word;
      mode_q    <= in_mode;
      idx_q     <= '0;
    end else if (word_done) begin
      out_valid <= 1'b0;
    end else if (out_fire) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(idx_q) && $stable(word_q) && $stable(mode_q));

  assert_first_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && idx_q == '0);

  assert_block_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !last |-> !in_ready);

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(in_valid && in_ready) |=> $stable(mode_q));
endmodule

// File: rtl/trace_unpk.sv
module trace_unpk
  import trace_unpk_pkg::*;
#(
  parameter int unsigned       WORD_W    = 32,
  parameter int unsigned       STAT_W    = 3,
  parameter int unsigned       PKT_W     = 16,
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        in_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [STAT_W-1:0] out_status,
  output logic [PKT_W-1:0]  out_packet,
  output logic              out_sync,
  output logic              out_trig
);
  localparam int unsigned IDX_W = $clog2(NARROW_RECS);

  logic [WORD_W-1:0] word_q;
  port_w_e           mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last;
  logic [STAT_W-1:0] raw_stat;

  trace_unpk_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .in_mode  (port_w_e'(in_mode)),
    .in_ready (in_ready),
    .out_ready(out_ready),
    .last     (last),
    .out_valid(out_valid),
    .word_q   (word_q),
    .mode_q   (mode_q),
    .idx_q    (idx_q)
  );

  trace_unpk_extract #(.WORD_W(WORD_W), .STAT_W(STAT_W), .PKT_W(PKT_W), .IDX_W(IDX_W)) u_ext (
    .word(word_q),
    .mode(mode_q),
    .idx (idx_q),
    .stat(raw_stat),
    .pkt (out_packet),
    .sync(out_sync),
    .last(last)
  );

  trace_unpk_trigfix #(.STAT_W(STAT_W), .PKT_W(PKT_W), .TRIG_CODE(TRIG_CODE)) u_trig (
    .stat_i(raw_stat),
    .pkt_i (out_packet),
    .stat_o(out_status),
    .trig_o(out_trig)
  );

  assert_trig_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_trig |-> out_status != TRIG_CODE);

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == PW_4 |-> out_packet[PKT_W-1:NARROW_PKT] == '0);
endmodule

// File: tb/trace_unpk_tb.sv
module trace_unpk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_status;
  logic [15:0] out_packet;
  logic        out_sync;
  logic        out_trig;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  int rdy_mode = 0;  // 0 always ready, 1 random, 2 stalled

  logic [20:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  trace_unpk u_dut (
    .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_status(out_status), .out_packet(out_packet),
    .out_sync(out_sync), .out_trig(out_trig)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // record layout in the scoreboard: {trig, sync, status[2:0], packet[15:0]}
  function automatic logic [20:0] mk(input logic [2:0] st, input logic [15:0] pk, input logic sy);
    if (st == 3'b110) return {1'b1, sy, pk[2:0], pk};
    return {1'b0, sy, st, pk};
  endfunction

  task automatic push(input logic [2:0] st, input logic [15:0] pk, input logic sy, input string t);
    logic [20:0] r;
    r = mk(st, pk, sy);
    exp_q.push_back(r);
    tag_q.push_back(r[20] ? {t, "/R6"} : t);
    pushed++;
  endtask

  task automatic send(input logic [1:0] m, input logic [31:0] w);
    case (m)
      2'b00: for (int k = 0; k < 3; k++)
        push(w[k*8 +: 3], {12'h000, w[k*8+3 +: 4]}, w[k*8+7], "R2/R5/R7/R10");
      2'b01: for (int k = 0; k < 2; k++)
        push(w[k*12 +: 3], {8'h00, w[k*12+3 +: 8]}, w[k*12+11], "R3/R5/R7/R10");
      default: push(w[2:0], w[18:3], w[19], "R4/R10");
    endcase
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_mode  = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_mode  = ~m;   // later mode changes must not touch the held word
    in_word  = ~w;
  endtask

  always begin
    @(posedge clk);
    #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 2);
  end

  // monitor: pops expected records on each handshake, checks stall stability
  logic        prev_stall = 1'b0;
  logic [20:0] prev_rec;
  always @(negedge clk) begin
    logic [20:0] got;
    got = {out_trig, out_sync, out_status, out_packet};
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && got == prev_rec, "R8 hold under stall", {10'd0, out_valid, got}, {11'h001, prev_rec});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected record", {11'd0, got}, 32'd0);
        end else begin
          logic [20:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, {11'd0, got}, {11'd0, e});
          popped++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_rec   = got;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R2: 4-bit words, trigger code placed in each slot
    rdy_mode = 0;
    send(2'b00, 32'h00A5_3C81);
    send(2'b00, 32'h0000_00D6);          // slot 0 trigger, packet low bits 010
    send(2'b00, 32'h0000_FE00);          // slot 1 trigger
    send(2'b00, 32'h00BE_0000);          // slot 2 trigger
    // R3: 8-bit words, trigger in each slot
    send(2'b01, 32'h0087_6543);
    send(2'b01, 32'h0000_0AAE);
    send(2'b01, 32'h00FF_E000);
    // R4: 16-bit words in both wide codes
    send(2'b10, 32'hFFFF_FFFF);
    send(2'b11, 32'h000A_BCD5);
    send(2'b10, 32'h0005_4326);          // trigger, packet low bits 100

    // R9: stalled consumer keeps input blocked while records wait
    rdy_mode = 2;
    send(2'b00, 32'h0012_3456);
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R9 input blocked", {31'd0, in_ready}, 32'd0);
    end
    rdy_mode = 0;

    // mixed modes under random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 60; i++) send(2'($urandom % 4), $urandom);
    rdy_mode = 0;
    for (int i = 0; i < 20; i++) send(2'(i % 4), $urandom);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(popped == pushed, "R5 record count", popped, pushed);
    check(out_valid == 1'b0, "R9 idle after drain", {31'd0, out_valid}, 32'd0);
    summary();
  end
endmodule